// File: doc/BRIEF.md
# Pipelined Row Readout Sequencer

This block walks a column-parallel-ADC image sensor through a window of pixel rows. For each row it places the row number on a 10-bit address bus and pulses an active-low conversion strobe. It then waits for the sensor's active-low completion line, which is asynchronous to the block clock and passes through a synchronizer. After completion it moves the converted row into the sensor's output register with an active-low load strobe. Last, it holds an active-low read-enable strobe low for one clock per column, and raises a row-valid marker during those clocks for the downstream capture logic.

Two schedules are selectable per frame. In overlapped (pipelined) mode, the conversion of the next row starts while the previous row is still being read out. The first row of a frame therefore yields no data until its own readout, and one readout with no new conversion flushes the last row. In burst mode, a conversion is never started until the readout of the previous row has fully finished. A conversion that gets no completion within a programmable number of clocks raises an error flag and sends the sequencer back to idle.

Top module: `row_readout_seq`

## Requirements
- R1: During and after reset, row_start_n, ld_shift_n and read_en_n are high, and row_valid, busy and timeout_err are low.
- R2: A frame_start pulse while idle converts rows win_first up to win_last in ascending order. Each conversion opens with row_start_n low for exactly one clock. When win_last is below win_first, only win_first is converted.
- R3: row_addr holds the converting row's number from the row_start_n pulse until the completion is accepted.
- R4: Each readout drives ld_shift_n low for exactly one clock, then read_en_n low for exactly READ_CYCLES clocks starting the next clock. row_valid is high in exactly those clocks, and rd_row carries the row being read out.
- R5: row_start_n never goes low in the clock in which read_en_n falls, nor in the clock after it.
- R6: With burst_mode low at frame_start, each conversion after the first starts while the previous row's read_en_n is low, and every converted row is read out once, the last one included.
- R7: With burst_mode high at frame_start, row_start_n never goes low while ld_shift_n or read_en_n is low, and every converted row is read out once.
- R8: If no falling edge of row_done_n is accepted within DONE_TIMEOUT clocks of a row_start_n pulse, timeout_err rises exactly DONE_TIMEOUT clocks after the pulse, and busy drops in the same clock. The next frame_start clears timeout_err.
- R9: frame_start, win_first, win_last and burst_mode are sampled only when a frame starts from idle. Changing them, or pulsing frame_start, while busy leaves the running frame unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Starts a frame when idle |
| burst_mode | input | 1 | 1 = burst schedule, 0 = overlapped schedule |
| win_first | input | ADDR_W | First row of the window |
| win_last | input | ADDR_W | Last row of the window |
| row_done_n | input | 1 | Sensor conversion-complete line, active low, asynchronous |
| row_start_n | output | 1 | Row conversion strobe, active low |
| row_addr | output | ADDR_W | Row address presented to the sensor |
| ld_shift_n | output | 1 | Load-to-output-register strobe, active low |
| read_en_n | output | 1 | Data read enable, active low |
| row_valid | output | 1 | High while a row's pixel data streams out |
| rd_row | output | ADDR_W | Row number of the data being streamed |
| busy | output | 1 | Frame or readout in progress |
| timeout_err | output | 1 | Conversion completion missed |

## Verification
The hardest state to reach is a conversion that is started in the middle of a readout. Only in that state can the two-clock spacing after the read-enable fall and the address hold both be stressed at once. It needs a sensor that answers a conversion neither too early nor too late relative to the read length. The bench runs a behavioural sensor model whose response delay each table vector sets, both shorter and longer than the readout. It also mutes the model so that a conversion goes unanswered, which drives the timeout path and the recovery frame after it.

// File: rtl/rro_pkg.sv
package rro_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CONV,
      SQ_LOAD,
      SQ_GAP,
      SQ_DRAIN
   } sq_state_e;

   typedef enum logic [1:0] {
      RD_IDLE,
      RD_LOAD,
      RD_READ
   } rd_phase_e;
endpackage

// File: rtl/rro_sync.sv
module rro_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic fall
);
   logic [STAGES:0] sq;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq[0] <= 1'b1;
            else        sq[0] <= async_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq[i] <= 1'b1;
            else        sq[i] <= sq[i-1];
         end
      end
   end

   assign fall = sq[STAGES] & ~sq[STAGES-1];
endmodule

// File: rtl/rro_conv.sv
module rro_conv #(
   parameter int ADDR_W  = 10,
   parameter int TIMEOUT = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] addr,
   input  logic              done_fall,
   output logic              row_start_n,
   output logic [ADDR_W-1:0] row_addr,
   output logic              busy,
   output logic              done,
   output logic              timeout
);
   logic to_hit;

   if (TIMEOUT > 0) begin : g_timer
      localparam int TO_W = $clog2(TIMEOUT + 1);
      logic [TO_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (go && !busy) cnt <= '0;
         else if (busy)        cnt <= cnt + TO_W'(1);
      end
      assign to_hit = busy && (cnt == TO_W'(TIMEOUT - 1));
   end else begin : g_no_timer
      assign to_hit = 1'b0;
   end

   assign done    = busy & done_fall;
   assign timeout = busy & ~done_fall & to_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         row_start_n <= 1'b1;
         row_addr    <= '0;
      end else begin
         row_start_n <= 1'b1;
         if (go && !busy) begin
            busy        <= 1'b1;
            row_addr    <= addr;
            row_start_n <= 1'b0;
         end else if (done || timeout) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rro_read.sv
module rro_read import rro_pkg::*; #(
   parameter int ADDR_W      = 10,
   parameter int READ_CYCLES = 1280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] row_in,
   output logic              ld_shift_n,
   output logic              read_en_n,
   output logic              row_valid,
   output logic [ADDR_W-1:0] rd_row,
   output logic              busy,
   output logic              gap_ok
);
   localparam int CNT_W = $clog2(READ_CYCLES + 1);

   rd_phase_e        phase;
   logic [CNT_W-1:0] cnt;

   assign busy   = (phase != RD_IDLE);
   assign gap_ok = (phase == RD_IDLE) || ((phase == RD_READ) && (cnt != '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= RD_IDLE;
         cnt        <= '0;
         ld_shift_n <= 1'b1;
         read_en_n  <= 1'b1;
         row_valid  <= 1'b0;
         rd_row     <= '0;
      end else begin
         case (phase)
            RD_IDLE: if (go) begin
               phase      <= RD_LOAD;
               ld_shift_n <= 1'b0;
               rd_row     <= row_in;
            end
            RD_LOAD: begin
               phase      <= RD_READ;
               ld_shift_n <= 1'b1;
               read_en_n  <= 1'b0;
               row_valid  <= 1'b1;
               cnt        <= '0;
            end
            RD_READ: begin
               if (cnt == CNT_W'(READ_CYCLES - 1)) begin
                  phase     <= RD_IDLE;
                  read_en_n <= 1'b1;
                  row_valid <= 1'b0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: phase <= RD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/row_readout_seq.sv
module row_readout_seq import rro_pkg::*; #(
   parameter int ADDR_W       = 10,
   parameter int READ_CYCLES  = 1280,
   parameter int DONE_TIMEOUT = 4096,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              burst_mode,
   input  logic [ADDR_W-1:0] win_first,
   input  logic [ADDR_W-1:0] win_last,
   input  logic              row_done_n,
   output logic              row_start_n,
   output logic [ADDR_W-1:0] row_addr,
   output logic              ld_shift_n,
   output logic              read_en_n,
   output logic              row_valid,
   output logic [ADDR_W-1:0] rd_row,
   output logic              busy,
   output logic              timeout_err
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (READ_CYCLES < 1) begin : g_bad_read
      $error("READ_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (DONE_TIMEOUT < 0) begin : g_bad_to
      $error("DONE_TIMEOUT must not be negative");
   end

   sq_state_e         st;
   logic [ADDR_W-1:0] cur, last_q, conv_addr;
   logic              mode_q, at_last;
   logic              done_fall, conv_go, conv_busy, conv_done, conv_to;
   logic              rd_go, rd_busy, gap_ok;

   rro_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_n(row_done_n), .fall(done_fall)
   );

   rro_conv #(.ADDR_W(ADDR_W), .TIMEOUT(DONE_TIMEOUT)) u_conv (
      .clk(clk), .rst_n(rst_n), .go(conv_go), .addr(conv_addr),
      .done_fall(done_fall), .row_start_n(row_start_n), .row_addr(row_addr),
      .busy(conv_busy), .done(conv_done), .timeout(conv_to)
   );

   rro_read #(.ADDR_W(ADDR_W), .READ_CYCLES(READ_CYCLES)) u_read (
      .clk(clk), .rst_n(rst_n), .go(rd_go), .row_in(cur),
      .ld_shift_n(ld_shift_n), .read_en_n(read_en_n), .row_valid(row_valid),
      .rd_row(rd_row), .busy(rd_busy), .gap_ok(gap_ok)
   );

   assign at_last = (cur >= last_q);
   assign busy    = (st != SQ_IDLE) || rd_busy || conv_busy;

   always_comb begin
      conv_go   = 1'b0;
      conv_addr = cur;
      rd_go     = 1'b0;
      case (st)
         SQ_IDLE: begin
            conv_go   = frame_start && !rd_busy;
            conv_addr = win_first;
         end
         SQ_LOAD:  rd_go   = !rd_busy;
         SQ_GAP:   conv_go = gap_ok;
         SQ_DRAIN: begin
            conv_go   = !rd_busy && !at_last;
            conv_addr = cur + ADDR_W'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SQ_IDLE;
         cur         <= '0;
         last_q      <= '0;
         mode_q      <= 1'b0;
         timeout_err <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: if (conv_go) begin
               cur         <= win_first;
               last_q      <= win_last;
               mode_q      <= burst_mode;
               timeout_err <= 1'b0;
               st          <= SQ_CONV;
            end
            SQ_CONV: begin
               if (conv_to) begin
                  timeout_err <= 1'b1;
                  st          <= SQ_IDLE;
               end else if (conv_done) begin
                  st <= SQ_LOAD;
               end
            end
            SQ_LOAD: if (rd_go) begin
               if (mode_q) begin
                  st <= SQ_DRAIN;
               end else if (at_last) begin
                  st <= SQ_IDLE;
               end else begin
                  cur <= cur + ADDR_W'(1);
                  st  <= SQ_GAP;
               end
            end
            SQ_GAP: if (conv_go) st <= SQ_CONV;
            SQ_DRAIN: if (!rd_busy) begin
               if (at_last) begin
                  st <= SQ_IDLE;
               end else begin
                  cur <= cur + ADDR_W'(1);
                  st  <= SQ_CONV;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/row_seq_chk.sv
module row_seq_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              row_start_n,
   input logic              ld_shift_n,
   input logic              read_en_n,
   input logic [ADDR_W-1:0] row_addr,
   input logic              conv_busy,
   input logic              mode_q
);
   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !row_start_n |=> row_start_n);

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_busy && $past(conv_busy) |-> $stable(row_addr));

   assert_ld_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_shift_n |=> ld_shift_n);

   assert_ld_before_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(read_en_n) |-> !$past(ld_shift_n));

   assert_start_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(read_en_n) |-> row_start_n ##1 row_start_n);

   assert_burst_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q && !row_start_n |-> read_en_n && ld_shift_n);
endmodule

bind row_readout_seq row_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .row_start_n(row_start_n), .ld_shift_n(ld_shift_n),
   .read_en_n(read_en_n), .row_addr(row_addr), .conv_busy(conv_busy), .mode_q(mode_q)
);

// File: tb/sim_row_readout_seq.sv
module sim_row_readout_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int RC = 8;
   localparam int TO = 64;

   typedef struct packed {
      logic [9:0] first;
      logic [9:0] last;
      logic       burst;
      logic [7:0] dly;
      logic [7:0] exp_n;
      logic [7:0] exp_ov;
   } vec_t;

   localparam vec_t VECS [0:5] = '{
      '{10'd3,    10'd7,    1'b0, 8'd5,  8'd5, 8'd4},
      '{10'd3,    10'd7,    1'b1, 8'd5,  8'd5, 8'd0},
      '{10'd1020, 10'd1023, 1'b0, 8'd20, 8'd4, 8'd3},
      '{10'd10,   10'd10,   1'b0, 8'd3,  8'd1, 8'd0},
      '{10'd9,    10'd2,    1'b1, 8'd2,  8'd1, 8'd0},
      '{10'd0,    10'd2,    1'b0, 8'd1,  8'd3, 8'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          burst_mode = 1'b0;
   logic [AW-1:0] win_first = '0;
   logic [AW-1:0] win_last = '0;
   logic          row_done_n = 1'b1;
   logic          row_start_n, ld_shift_n, read_en_n, row_valid, busy, timeout_err;
   logic [AW-1:0] row_addr, rd_row;

   int  checks = 0;
   int  fails = 0;
   bit  sens_en = 1'b1;
   int  conv_dly = 5;

   int          cyc = 0;
   int          n_conv, n_rd, ov, gap_bad, hold_bad, ord_bad, vbad, vcnt;
   int          last_dre_fall;
   int          conv_rows [0:63];
   int          rd_rows [0:63];
   bit          pend;
   logic [AW-1:0] hold_v;
   logic        prev_rs = 1'b1, prev_ld = 1'b1, prev_dre = 1'b1;

   row_readout_seq #(.ADDR_W(AW), .READ_CYCLES(RC), .DONE_TIMEOUT(TO), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .burst_mode(burst_mode),
      .win_first(win_first), .win_last(win_last), .row_done_n(row_done_n),
      .row_start_n(row_start_n), .row_addr(row_addr), .ld_shift_n(ld_shift_n),
      .read_en_n(read_en_n), .row_valid(row_valid), .rd_row(rd_row),
      .busy(busy), .timeout_err(timeout_err)
   );

   initial forever #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_conv = 0; n_rd = 0; ov = 0; gap_bad = 0; hold_bad = 0;
      ord_bad = 0; vbad = 0; vcnt = 0; pend = 1'b0; last_dre_fall = -100;
   endtask

   // behavioural sensor: answers each conversion strobe after conv_dly clocks
   initial forever begin
      @(negedge clk);
      if (sens_en && rst_n && !row_start_n) begin
         row_done_n = 1'b1;
         repeat (conv_dly) @(negedge clk);
         row_done_n = 1'b0;
      end
   end

   // port monitor, sampled on the falling edge
   initial forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
         if (!row_start_n && prev_rs) begin
            if (n_conv < 64) conv_rows[n_conv] = int'(row_addr);
            n_conv++;
            if (!read_en_n || !ld_shift_n) ov++;
            if (cyc - last_dre_fall < 2) gap_bad++;
            pend = 1'b1;
            hold_v = row_addr;
         end else if (pend) begin
            if (row_addr != hold_v) hold_bad++;
            if (!row_done_n) pend = 1'b0;
         end
         if (!ld_shift_n && prev_ld) begin
            if (n_rd < 64) rd_rows[n_rd] = int'(rd_row);
            n_rd++;
         end
         if (!ld_shift_n && !prev_ld) ord_bad++;
         if (!read_en_n && prev_dre) begin
            last_dre_fall = cyc;
            if (prev_ld) ord_bad++;
         end
         if (row_valid) begin
            vcnt++;
            if (read_en_n) vbad++;
         end else if (!read_en_n) vbad++;
         if (read_en_n && !prev_dre) begin
            if (vcnt != RC) vbad++;
            vcnt = 0;
         end
      end
      prev_rs  = row_start_n;
      prev_ld  = ld_shift_n;
      prev_dre = read_en_n;
   end

   task automatic start_frame(input logic [AW-1:0] f, input logic [AW-1:0] l, input logic b);
      @(negedge clk);
      win_first = f; win_last = l; burst_mode = b; frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      repeat (2) @(negedge clk);
      // R9: disturb every sampled input while the frame runs
      win_first = f + 10'd200; win_last = l ^ 10'h155; burst_mode = ~b; frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      win_first = f; win_last = l; burst_mode = b;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000; i++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (5000 * 30) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int bad;
      clear_mon();
      repeat (3) @(negedge clk);
      chk(row_start_n && ld_shift_n && read_en_n, "R1 strobes in reset",
          {row_start_n, ld_shift_n, read_en_n}, 7);
      chk(!row_valid && !busy && !timeout_err, "R1 flags in reset",
          {row_valid, busy, timeout_err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(row_start_n && ld_shift_n && read_en_n && !row_valid && !busy && !timeout_err,
          "R1 idle after reset",
          {row_start_n, ld_shift_n, read_en_n, row_valid, busy, timeout_err}, 56);

      for (int v = 0; v < 6; v++) begin
         clear_mon();
         conv_dly = int'(VECS[v].dly);
         start_frame(VECS[v].first, VECS[v].last, VECS[v].burst);
         wait_idle();
         repeat (2) @(negedge clk);
         chk(n_conv == int'(VECS[v].exp_n), "R2 conversion count", n_conv, int'(VECS[v].exp_n));
         bad = 0;
         for (int k = 0; k < n_conv && k < 64; k++)
            if (conv_rows[k] != int'(VECS[v].first) + k) bad++;
         chk(bad == 0, "R2 R9 conversion order within latched window", bad, 0);
         chk(n_rd == int'(VECS[v].exp_n), VECS[v].burst ? "R7 readout count" : "R6 readout count",
             n_rd, int'(VECS[v].exp_n));
         bad = 0;
         for (int k = 0; k < n_rd && k < 64; k++)
            if (rd_rows[k] != int'(VECS[v].first) + k) bad++;
         chk(bad == 0, "R4 rd_row sequence", bad, 0);
         chk(ov == int'(VECS[v].exp_ov), VECS[v].burst ? "R7 overlap" : "R6 overlap",
             ov, int'(VECS[v].exp_ov));
         chk(hold_bad == 0, "R3 address hold", hold_bad, 0);
         chk(gap_bad == 0, "R5 start spacing", gap_bad, 0);
         chk(ord_bad == 0 && vbad == 0, "R4 strobe order and valid width", ord_bad + vbad, 0);
         chk(!timeout_err, "R8 no error on answered frame", timeout_err, 0);
      end

      // R8: unanswered conversion
      clear_mon();
      sens_en = 1'b0;
      row_done_n = 1'b1;
      @(negedge clk);
      win_first = 10'd5; win_last = 10'd6; burst_mode = 1'b0; frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      chk(!row_start_n, "R8 strobe issued", row_start_n, 0);
      begin
         int k;
         k = 0;
         while (!timeout_err && k < 500) begin
            @(negedge clk);
            k++;
         end
         chk(k == TO, "R8 timeout latency", k, TO);
         chk(!busy, "R8 idle after timeout", busy, 0);
      end
      chk(n_conv == 1 && n_rd == 0, "R8 no readout after timeout", n_rd, 0);

      sens_en = 1'b1;
      clear_mon();
      conv_dly = 4;
      start_frame(10'd20, 10'd21, 1'b1);
      chk(!timeout_err, "R8 error cleared by frame_start", timeout_err, 0);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(n_conv == 2 && n_rd == 2, "R8 recovery frame completes", n_rd, 2);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule